// File: doc/BRIEF.md
# Virtual Page Map Controller

This block keeps a table of page map entries. The table is indexed by virtual page number. Each 16-bit entry holds a 13-bit real page number and three flags: write-protect (w), dirty (d) and referenced (r). The real page is stored in two pieces, one on each side of the flags. This layout lets a 13th page bit be kept without widening the word.

A client issues one of three commands through a valid/ready request port:

- **Set-map** writes a complete entry.
- **Set-flags** replaces only the flags and keeps the stored real page. A vacant entry is the exception: it keeps its vacant flags.
- **Get-flags** reads the entry and changes nothing.

Every command answers two cycles after it is accepted. The answer carries the previous entry in two forms: the raw stored word, and the real page and flags unpacked. It also carries two permission bits. These say whether a read or a write may go ahead against that entry without changing it.

After reset the block walks the whole table and writes the vacant code into every entry. It holds off requests until the walk is done. Commands may be issued back to back, including to the same page.

Top module: `vpmap_ctrl`

## Requirements
- R1: After reset every table entry reads back as the vacant word 16'h0600. The initialisation walk lasts one cycle per entry, and `req_ready` rises within depth+4 cycles of reset release.
- R2: Entry layout is fixed. Bits [15:12] hold page[3:0] and bits [8:0] hold page[12:4]. Bit 9 holds w, bit 10 holds d and bit 11 holds r. The flag argument maps `req_flags[2]`=w, `req_flags[1]`=d and `req_flags[0]`=r; `req_flags[15:3]` are ignored.
- R3: Set-map (`req_cmd`=1) stores `req_rpage[12:0]` with the requested flags. `req_rpage[15:13]` are ignored.
- R4: Set-flags (`req_cmd`=2) stores the old real page with the new flags. If the old flags were vacant (w,d,r = 1,1,0), the entry stays vacant.
- R5: Get-flags (`req_cmd`=0) and the spare code `req_cmd`=3 leave the entry unchanged.
- R6: Every response returns the entry as it was before the command, both as `rsp_entry` and unpacked into `rsp_rpage` (13-bit contiguous) and `rsp_flags` ({w,d,r}).
- R7: `rsp_rd_ok` is 1 exactly for old flag codes 001, 011, 101 and 111.
- R8: `rsp_wr_ok` is 1 exactly for old flag codes 010 and 011.
- R9: A command accepted in cycle n gives a one-cycle `rsp_valid` pulse in cycle n+2, with `rsp_cmd` echoing the command.
- R10: A command accepted in the cycle right after another command to the same table index sees that command's update.
- R11: `req_ready` is low during reset and during the initialisation walk, and high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Block can accept a command |
| req_cmd | input | 2 | 0 get-flags, 1 set-map, 2 set-flags, 3 spare (read only) |
| req_vpage | input | 16 | Virtual page; the low ADDR_W bits index the table |
| req_rpage | input | 16 | Real page for set-map; low 13 bits used |
| req_flags | input | 16 | New flags; low 3 bits used as {w,d,r} |
| rsp_valid | output | 1 | Response strobe |
| rsp_cmd | output | 2 | Command being answered |
| rsp_rpage | output | 13 | Old real page, unpacked |
| rsp_flags | output | 3 | Old flags {w,d,r} |
| rsp_entry | output | 16 | Old raw entry word |
| rsp_rd_ok | output | 1 | Read may proceed on the old entry |
| rsp_wr_ok | output | 1 | Write may proceed on the old entry |

## Verification
A faulty stored entry cannot be seen until a later command touches the same index. At that point the mismatch shows two cycles after acceptance, in `rsp_entry` and in the unpacked fields together. The bench therefore reads back every index it writes, through sequences of write-then-get and same-index back-to-back commands. A broken bypass path only appears on the second of two consecutive commands to one page, so those pairs are issued on purpose and also arise from the mixed random traffic. Permission errors appear on the same response as the flags, so all eight flag codes are read back at least once.

// File: rtl/vpmap_pkg.sv
package vpmap_pkg;
  localparam int ENTRY_W = 16;
  localparam int RPAGE_W = 13;
  localparam int FLAG_W  = 3;

  typedef enum logic [1:0] {
    CMD_GET    = 2'd0,
    CMD_SETMAP = 2'd1,
    CMD_SETFLG = 2'd2,
    CMD_PEEK   = 2'd3
  } vpm_cmd_e;

  // flags are {w,d,r}
  localparam logic [FLAG_W-1:0] FLG_VACANT = 3'b110;

  // Entry layout: [15:12] page[3:0], [11] r, [10] d, [9] w, [8:0] page[12:4]
  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [RPAGE_W-1:0] pg,
                                                    input logic [FLAG_W-1:0] fl);
    pack_entry = {pg[3:0], fl[0], fl[1], fl[2], pg[12:4]};
  endfunction

  localparam logic [ENTRY_W-1:0] VACANT_WORD = {4'h0, 1'b0, 1'b1, 1'b1, 9'h000};
endpackage

// File: rtl/vpmap_ram.sv
module vpmap_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first simple dual port, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vpmap_sweep.sv
module vpmap_sweep #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) busy <= 1'b0;
    end
  end

  AST_SWEEP_COVERS_ALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(addr) == LAST); // R1
endmodule

// File: rtl/vpmap_decode.sv
module vpmap_decode
  import vpmap_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output logic [RPAGE_W-1:0] rpage,
  output logic [FLAG_W-1:0]  flags,
  output logic               rd_ok,
  output logic               wr_ok
);
  logic w_bit, d_bit, r_bit;

  always_comb begin
    w_bit = entry[9];
    d_bit = entry[10];
    r_bit = entry[11];
    rpage = {entry[8:0], entry[15:12]};
    flags = {w_bit, d_bit, r_bit};
    rd_ok = r_bit;
    wr_ok = !w_bit && d_bit;
  end
endmodule

// File: rtl/vpmap_ctrl.sv
module vpmap_ctrl
  import vpmap_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int VPAGE_W = 16,
  parameter int ARG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_cmd,
  input  logic [VPAGE_W-1:0] req_vpage,
  input  logic [ARG_W-1:0]   req_rpage,
  input  logic [ARG_W-1:0]   req_flags,
  output logic               rsp_valid,
  output logic [1:0]         rsp_cmd,
  output logic [RPAGE_W-1:0] rsp_rpage,
  output logic [FLAG_W-1:0]  rsp_flags,
  output logic [ENTRY_W-1:0] rsp_entry,
  output logic               rsp_rd_ok,
  output logic               rsp_wr_ok
);
  logic              sweep_busy;
  logic [ADDR_W-1:0] sweep_addr;
  logic              acc;
  logic [ADDR_W-1:0] req_idx;

  // stage 1 state
  logic               s1_valid;
  vpm_cmd_e           s1_cmd;
  logic [ADDR_W-1:0]  s1_addr;
  logic [RPAGE_W-1:0] s1_page;
  logic [FLAG_W-1:0]  s1_flags;
  logic               fwd_hit;
  logic [ENTRY_W-1:0] fwd_word;

  logic [ENTRY_W-1:0] ram_q, old_word, upd_word;
  logic [RPAGE_W-1:0] old_page;
  logic [FLAG_W-1:0]  old_flags;
  logic               old_rd, old_wr, upd_we;

  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr;
  logic [ENTRY_W-1:0] mem_wdata;

  vpmap_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk (clk),
    .rst (rst),
    .busy(sweep_busy),
    .addr(sweep_addr)
  );

  assign req_ready = !sweep_busy;
  assign acc       = req_valid && req_ready;
  assign req_idx   = req_vpage[ADDR_W-1:0];

  vpmap_ram #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(req_idx),
    .rdata(ram_q)
  );

  // the entry may have been written by the previous command in the same edge
  assign old_word = fwd_hit ? fwd_word : ram_q;

  vpmap_decode u_dec (
    .entry(old_word),
    .rpage(old_page),
    .flags(old_flags),
    .rd_ok(old_rd),
    .wr_ok(old_wr)
  );

  always_comb begin
    upd_we   = 1'b0;
    upd_word = old_word;
    unique case (s1_cmd)
      CMD_SETMAP: begin
        upd_we   = 1'b1;
        upd_word = pack_entry(s1_page, s1_flags);
      end
      CMD_SETFLG: begin
        upd_we   = 1'b1;
        upd_word = pack_entry(old_page,
                              (old_flags == FLG_VACANT) ? FLG_VACANT : s1_flags);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (sweep_busy) begin
      mem_we    = 1'b1;
      mem_waddr = sweep_addr;
      mem_wdata = VACANT_WORD;
    end else begin
      mem_we    = s1_valid && upd_we;
      mem_waddr = s1_addr;
      mem_wdata = upd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      fwd_hit  <= 1'b0;
    end else begin
      s1_valid <= acc;
      fwd_hit  <= acc && s1_valid && upd_we && (s1_addr == req_idx);
    end
    if (acc) begin
      s1_cmd   <= vpm_cmd_e'(req_cmd);
      s1_addr  <= req_idx;
      s1_page  <= req_rpage[RPAGE_W-1:0];
      s1_flags <= req_flags[FLAG_W-1:0];
      fwd_word <= upd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_cmd   <= '0;
      rsp_rpage <= '0;
      rsp_flags <= '0;
      rsp_entry <= '0;
      rsp_rd_ok <= 1'b0;
      rsp_wr_ok <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_cmd   <= s1_cmd;
        rsp_rpage <= old_page;
        rsp_flags <= old_flags;
        rsp_entry <= old_word;
        rsp_rd_ok <= old_rd;
        rsp_wr_ok <= old_wr;
      end
    end
  end

  AST_ACCEPT_TO_STAGE: assert property (@(posedge clk) disable iff (rst)
    acc |=> s1_valid); // R9
  AST_STAGE_TO_RSP: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> rsp_valid); // R9
  AST_NO_ACCEPT_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |-> !s1_valid); // R11
  AST_VACANT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_cmd == CMD_SETFLG && old_flags == FLG_VACANT)
      |-> (mem_we && mem_wdata[11:9] == 3'b011)); // R4
  AST_GET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (s1_cmd == CMD_GET || s1_cmd == CMD_PEEK)) |-> !mem_we); // R5
  AST_WR_PERM_CODE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr_ok) |-> rsp_flags[2:1] == 2'b01); // R8
  AST_RD_PERM_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rd_ok == rsp_flags[0]); // R7
endmodule

// File: tb/tb_vpmap_ctrl.sv
module tb_vpmap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_cmd = 0;
  logic [15:0] req_vpage = 0, req_rpage = 0, req_flags = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_cmd;
  logic [12:0] rsp_rpage;
  logic [2:0]  rsp_flags;
  logic [15:0] rsp_entry;
  logic        rsp_rd_ok, rsp_wr_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpmap_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_vpage(req_vpage), .req_rpage(req_rpage),
    .req_flags(req_flags), .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd),
    .rsp_rpage(rsp_rpage), .rsp_flags(rsp_flags), .rsp_entry(rsp_entry),
    .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
  );

  int n_vec = 0, n_bad = 0;
  int cycles = 0;
  string cur_tag = "R1";
  bit compare_on = 0;

  // reference model
  logic [15:0] refm [DEPTH];
  bit          pend_v = 0, exp_v = 0;
  logic [1:0]  pend_cmd, exp_cmd;
  logic [15:0] pend_word, exp_word;

  function automatic logic [15:0] mk_word(input logic [12:0] pg, input logic [2:0] f);
    logic [15:0] w;
    w = 16'h0;
    w[15:12] = pg[3:0];
    w[8:0]   = pg[12:4];
    w[9]     = f[2];
    w[10]    = f[1];
    w[11]    = f[0];
    return w;
  endfunction

  function automatic logic [12:0] pg_of(input logic [15:0] w);
    logic [12:0] p;
    p[3:0]  = w[15:12];
    p[12:4] = w[8:0];
    return p;
  endfunction

  function automatic logic [2:0] fl_of(input logic [15:0] w);
    return {w[9], w[10], w[11]};
  endfunction

  initial for (int i = 0; i < DEPTH; i++) refm[i] = 16'h0600;

  always @(posedge clk) begin
    exp_v = pend_v; exp_cmd = pend_cmd; exp_word = pend_word;
    pend_v = 0;
    if (rst) exp_v = 0;
    else if (req_valid && req_ready) begin
      logic [ADDR_W-1:0] ix;
      logic [15:0] old;
      logic [2:0] of;
      ix = req_vpage[ADDR_W-1:0];
      old = refm[ix];
      of = fl_of(old);
      pend_v = 1; pend_cmd = req_cmd; pend_word = old;
      if (req_cmd == 2'd1) refm[ix] = mk_word(req_rpage[12:0], req_flags[2:0]);
      else if (req_cmd == 2'd2)
        refm[ix] = mk_word(pg_of(old), (of == 3'b110) ? 3'b110 : req_flags[2:0]);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s [%s]: actual %0h expected %0h", tag, what, cur_tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      logic [2:0] f;
      bit rd_e, wr_e;
      chk("R11", "req_ready", req_ready, 1);
      chk("R9", "rsp_valid", rsp_valid, exp_v);
      if (exp_v && rsp_valid) begin
        f = fl_of(exp_word);
        rd_e = (f == 3'b001) || (f == 3'b011) || (f == 3'b101) || (f == 3'b111);
        wr_e = (f == 3'b010) || (f == 3'b011);
        chk("R9", "rsp_cmd", rsp_cmd, exp_cmd);
        chk("R2", "rsp_entry", rsp_entry, exp_word);
        chk("R6", "rsp_rpage", rsp_rpage, pg_of(exp_word));
        chk("R6", "rsp_flags", rsp_flags, f);
        chk("R7", "rsp_rd_ok", rsp_rd_ok, rd_e);
        chk("R8", "rsp_wr_ok", rsp_wr_ok, wr_e);
      end
    end
  end

  task automatic issue(input logic [1:0] c, input logic [15:0] vp,
                       input logic [15:0] rp, input logic [15:0] fl);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_vpage = vp; req_rpage = rp; req_flags = fl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    int wait_cnt;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R11", "req_ready in reset", req_ready, 0);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R11", "req_ready during walk", req_ready, 0);
    wait_cnt = 1;
    while (!req_ready && wait_cnt < DEPTH + 10) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk("R1", "walk within depth+4", (wait_cnt <= DEPTH + 4), 1);
    compare_on = 1;

    // R1: fresh entries read back vacant
    cur_tag = "R1";
    issue(2'd0, 16'h0000, 0, 0);
    issue(2'd0, 16'h00FF, 0, 0);
    idle(3);

    // R2/R3: set-map all eight codes with junk upper bits, then read them
    cur_tag = "R3";
    for (int f = 0; f < 8; f++)
      issue(2'd1, 16'h0010 + f, 16'hE000 | (16'h1ABC ^ f), 16'hFFF8 | f);
    idle(2);
    cur_tag = "R2";
    for (int f = 0; f < 8; f++) issue(2'd0, 16'h0010 + f, 0, 0);
    idle(3);

    // R4: set-flags on each code; vacant (f=6) must stay vacant
    cur_tag = "R4";
    for (int f = 0; f < 8; f++) issue(2'd2, 16'h0010 + f, 16'h0, 16'h0008 | ((f + 3) % 8));
    idle(2);
    for (int f = 0; f < 8; f++) issue(2'd0, 16'h0010 + f, 0, 0);
    idle(3);

    // R5: get and spare code do not change entries
    cur_tag = "R5";
    issue(2'd0, 16'h0012, 16'h1234, 16'h0005);
    issue(2'd3, 16'h0012, 16'h1FFF, 16'h0007);
    issue(2'd0, 16'h0012, 0, 0);
    idle(3);

    // R10: back-to-back to one index
    cur_tag = "R10";
    issue(2'd1, 16'h0040, 16'h1F0F, 16'h0003);
    issue(2'd2, 16'h0040, 16'h0, 16'h0001);
    issue(2'd2, 16'h0040, 16'h0, 16'h0006);
    issue(2'd2, 16'h0040, 16'h0, 16'h0003);
    issue(2'd0, 16'h0040, 0, 0);
    issue(2'd0, 16'h0040, 0, 0);
    idle(3);

    // R6: mixed traffic over a few indices with aliasing upper bits
    cur_tag = "R6";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) issue(lf[2:1], {lf[15:11], 8'h00} | lf[5:3], {lf[7:0], lf[15:8]}, lf ^ 16'h5A5A);
      else idle(1);
    end
    idle(1);
    for (int i = 0; i < 8; i++) issue(2'd0, i, 0, 0);
    idle(4);
    finish_run();
  end
endmodule